// File: doc/BRIEF.md
# Flash program/erase controller

This block sits between a processor's register port and a small on-chip flash array, which it models as behavioural storage. Software writes a byte offset into the target-address register and loads four 32-bit data words. It then writes the control register once. That single write carries an unlock key, an erase-kind code and one start bit, which begins a 128-bit program, a page erase or a whole-array erase. While the operation runs, the controller holds busy. The length of each operation is a fixed number of microsecond ticks. The ticks come from a divider that software loads with the clock frequency in MHz. When the operation ends, the start bit clears.

Programming can only turn ones into zeros. Only an erase brings cells back to all ones. Each page has a write-enable bit and a read-enable bit. Software can clear these bits, but once cleared they cannot be set again until reset. Any illegal request raises a sticky fault flag, which software clears by writing 0 to it. A separate 32-bit read port returns array contents. For a read-protected page it returns a fixed value instead.

Top module: `flash_pe_ctrl`

Register map (byte offsets on `reg_addr`):

| Offset | Register | Contents |
|---|---|---|
| 0x00 | address | byte offset into the array |
| 0x04 | data word 0 | bits [31:0] of the 128-bit word, lowest address |
| 0x08 | data word 1 | bits [63:32] |
| 0x0C | data word 2 | bits [95:64] |
| 0x10 | data word 3 | bits [127:96] |
| 0x14 | control | [0] program start, [1] page-erase start, [2] whole-array-erase start, [11:8] erase code, [16] busy (read-only), [31:28] unlock key |
| 0x18 | fault flag | bit 0 |
| 0x1C | divider | [7:0], reset value 1 |
| 0x20 / 0x24 | write-enable | one bit per page: pages 0–31 / pages 32–63 |
| 0x28 / 0x2C | read-enable | same layout as write-enable |

## Requirements
- R1: After reset, busy and the fault flag are 0. Every array location reads all ones. Each write-enable and read-enable register holds a 1 for every existing page and 0 elsewhere. With the default 8 pages, offset 0x20 reads 0x000000FF and offset 0x24 reads 0.
- R2: A program ANDs the addressed 128-bit word with the value {data3,data2,data1,data0}, so bits can only go from 1 to 0. On the read port, offset bits [3:2] pick the 32-bit lane, and lane k is bits [32k+31:32k].
- R3: An operation keeps busy high for exactly TICKS×D clock cycles after the start write, where D is the divider value and a divider of 0 counts as 1. TICKS is PROG_TICKS (4) for a program and ERASE_TICKS (20) for either erase.
- R4: While an operation runs, control bit 16 reads 1 and the running start bit reads 1. Both read 0 once it ends.
- R5: A start write whose key field [31:28] is not 0x9 sets the fault flag and starts nothing.
- R6: While busy, a start write sets the fault flag and leaves the running operation intact. Writes to the address, data and divider registers are ignored while busy.
- R7: A program start with address bits [3:0] not zero sets the fault flag and starts nothing.
- R8: A page-erase start needs erase code 0xA, otherwise it sets the fault flag and starts nothing. A page erase sets every word of the addressed page to all ones and touches no other page.
- R9: A whole-array erase needs erase code 0x5. It sets every word to all ones, unless some page is write-protected. In that case the operation runs its full length, leaves the array unchanged and sets the fault flag.
- R10: Writing 1 to a write-enable bit clears it, and no write can set it again before reset. A program or erase aimed at a cleared page runs its full length, leaves the array unchanged, sets the fault flag and clears its start bit.
- R11: Read-enable bits are sticky in the same way. A read-port access to a page whose bit is cleared returns 0x00000000.
- R12: Writing 0 to fault bit 0 clears the flag. Writing 1 leaves it unchanged.
- R13: The address register keeps only the low AW offset bits of a written value. The page is offset bits [AW-1:log2(PAGE_BYTES)].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 8 | register byte offset |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data for reg_addr (combinational) |
| arr_raddr | input | AW (9) | array byte offset for reads |
| arr_rdata | output | 32 | 32-bit lane read from the array, or 0 if read-protected |
| busy | output | 1 | an operation is in progress |
| fault_irq | output | 1 | sticky access-fault flag |

## Verification
A corrupted tick counter or prescaler shows up as a busy pulse of the wrong length. It is visible at the busy pin within one operation, and the bench measures that pulse to the exact cycle. A wrong page or word index, or a lost AND-merge, shows up in the full sweep of the read port that follows every operation. A mis-held protection or start bit shows up at the very next register read or fault-flag sample. Every word lane is compared against an arithmetic model after each step, so a bad write surfaces before the next stimulus.

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl #(
  parameter int          PAGES       = 8,
  parameter int          PAGE_BYTES  = 64,
  parameter int          PROG_TICKS  = 4,
  parameter int          ERASE_TICKS = 20,
  parameter logic [31:0] FIXED_RD    = 32'h0,
  localparam int         AW          = $clog2(PAGES * PAGE_BYTES),
  localparam int         PG_LSB      = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [AW-1:0] arr_raddr,
  output logic [31:0]   arr_rdata,
  output logic          busy,
  output logic          fault_irq
);
  localparam int WPP   = PAGE_BYTES / 16;
  localparam int WORDS = PAGES * WPP;
  localparam int PG_W  = AW - PG_LSB;
  localparam logic [63:0] PG_MASK = (PAGES >= 64) ? {64{1'b1}} : ((64'd1 << PAGES) - 64'd1);

  localparam logic [7:0] A_ADDR = 8'h00, A_D0 = 8'h04, A_D1 = 8'h08, A_D2 = 8'h0C, A_D3 = 8'h10;
  localparam logic [7:0] A_CTRL = 8'h14, A_FLAG = 8'h18, A_DIV = 8'h1C;
  localparam logic [7:0] A_WLO = 8'h20, A_WHI = 8'h24, A_RLO = 8'h28, A_RHI = 8'h2C;
  localparam logic [3:0] KEY_OPEN = 4'h9, CODE_PAGE = 4'hA, CODE_ALL = 4'h5;

  logic [AW-1:0]  addr_q;
  logic [31:0]    data_q [4];
  logic           go_prog, go_page, go_all;
  logic [3:0]     key_q, code_q;
  logic           fault_q;
  logic [7:0]     div_q, pre_q;
  logic [15:0]    left_q;
  logic [63:0]    wen_q, ren_q;
  logic [127:0]   mem [WORDS];

  assign busy      = go_prog | go_page | go_all;
  assign fault_irq = fault_q;

  wire            ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  wire            go_req  = |reg_wdata[2:0];
  wire [3:0]      w_key   = reg_wdata[31:28];
  wire [3:0]      w_code  = reg_wdata[11:8];
  wire [7:0]      div_eff = (div_q == 8'd0) ? 8'd1 : div_q;
  wire            tick    = (pre_q == div_eff - 8'd1);
  wire [PG_W-1:0] tgt_pg  = addr_q[AW-1:PG_LSB];
  wire [AW-5:0]   tgt_wd  = addr_q[AW-1:4];
  wire            tgt_ok  = wen_q[tgt_pg];
  wire            any_wp  = |(~wen_q & PG_MASK);
  wire [127:0]    newval  = {data_q[3], data_q[2], data_q[1], data_q[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      for (int k = 0; k < 4; k++) data_q[k] <= '0;
      go_prog <= 1'b0;
      go_page <= 1'b0;
      go_all  <= 1'b0;
      key_q   <= '0;
      code_q  <= '0;
      fault_q <= 1'b0;
      div_q   <= 8'd1;
      pre_q   <= '0;
      left_q  <= '0;
      wen_q   <= PG_MASK;
      ren_q   <= PG_MASK;
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      if (reg_wr && !busy) begin
        case (reg_addr)
          A_ADDR:  addr_q    <= reg_wdata[AW-1:0];
          A_D0:    data_q[0] <= reg_wdata;
          A_D1:    data_q[1] <= reg_wdata;
          A_D2:    data_q[2] <= reg_wdata;
          A_D3:    data_q[3] <= reg_wdata;
          A_DIV:   div_q     <= reg_wdata[7:0];
          default: ;
        endcase
      end
      if (reg_wr) begin
        case (reg_addr)
          A_WLO:   wen_q[31:0]  <= wen_q[31:0]  & ~reg_wdata;
          A_WHI:   wen_q[63:32] <= wen_q[63:32] & ~reg_wdata;
          A_RLO:   ren_q[31:0]  <= ren_q[31:0]  & ~reg_wdata;
          A_RHI:   ren_q[63:32] <= ren_q[63:32] & ~reg_wdata;
          default: ;
        endcase
      end
      if (reg_wr && reg_addr == A_FLAG && !reg_wdata[0]) fault_q <= 1'b0;

      if (ctrl_wr) begin
        if (busy) begin
          if (go_req) fault_q <= 1'b1;
        end else begin
          key_q  <= w_key;
          code_q <= w_code;
          pre_q  <= '0;
          if (go_req) begin
            if (w_key != KEY_OPEN) begin
              fault_q <= 1'b1;
            end else if (reg_wdata[0]) begin
              if (addr_q[3:0] != 4'd0) fault_q <= 1'b1;
              else begin
                go_prog <= 1'b1;
                left_q  <= 16'(PROG_TICKS);
              end
            end else if (reg_wdata[1]) begin
              if (w_code != CODE_PAGE) fault_q <= 1'b1;
              else begin
                go_page <= 1'b1;
                left_q  <= 16'(ERASE_TICKS);
              end
            end else begin
              if (w_code != CODE_ALL) fault_q <= 1'b1;
              else begin
                go_all <= 1'b1;
                left_q <= 16'(ERASE_TICKS);
              end
            end
          end
        end
      end

      if (busy) begin
        if (!tick) begin
          pre_q <= pre_q + 8'd1;
        end else begin
          pre_q <= '0;
          if (left_q > 16'd1) begin
            left_q <= left_q - 16'd1;
          end else begin
            left_q  <= '0;
            go_prog <= 1'b0;
            go_page <= 1'b0;
            go_all  <= 1'b0;
            if (go_prog) begin
              if (tgt_ok) mem[tgt_wd] <= mem[tgt_wd] & newval;
              else        fault_q <= 1'b1;
            end else if (go_page) begin
              if (tgt_ok) begin
                for (int j = 0; j < WPP; j++) mem[int'(tgt_pg) * WPP + j] <= '1;
              end else fault_q <= 1'b1;
            end else begin
              if (any_wp) fault_q <= 1'b1;
              else for (int i = 0; i < WORDS; i++) mem[i] <= '1;
            end
          end
        end
      end
    end
  end

  wire [PG_W-1:0] rd_pg   = arr_raddr[AW-1:PG_LSB];
  wire [127:0]    rd_word = mem[arr_raddr[AW-1:4]];
  assign arr_rdata = ren_q[rd_pg] ? rd_word[32*arr_raddr[3:2] +: 32] : FIXED_RD;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ADDR:  reg_rdata[AW-1:0] = addr_q;
      A_D0:    reg_rdata = data_q[0];
      A_D1:    reg_rdata = data_q[1];
      A_D2:    reg_rdata = data_q[2];
      A_D3:    reg_rdata = data_q[3];
      A_CTRL:  reg_rdata = {key_q, 11'd0, busy, 4'd0, code_q, 5'd0, go_all, go_page, go_prog};
      A_FLAG:  reg_rdata = {31'd0, fault_q};
      A_DIV:   reg_rdata = {24'd0, div_q};
      A_WLO:   reg_rdata = wen_q[31:0];
      A_WHI:   reg_rdata = wen_q[63:32];
      A_RLO:   reg_rdata = ren_q[31:0];
      A_RHI:   reg_rdata = ren_q[63:32];
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/flash_pe_ctrl_chk.sv
module flash_pe_ctrl_chk #(
  parameter int          AW       = 9,
  parameter int          PG_LSB   = 6,
  parameter logic [31:0] FIXED_RD = 32'h0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [7:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          busy,
  input logic          fault_irq,
  input logic [63:0]   wen,
  input logic [63:0]   ren,
  input logic [AW-1:0] arr_raddr,
  input logic [31:0]   arr_rdata
);
  wire start_wr = reg_wr && reg_addr == 8'h14 && (|reg_wdata[2:0]);

  p_lock_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr && !busy && reg_wdata[31:28] != 4'h9 |=> fault_irq && !busy);

  p_busy_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr && busy |=> fault_irq);

  p_wen_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wen & ~$past(wen)) == 64'd0));

  p_ren_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ren & ~$past(ren)) == 64'd0));

  p_rd_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ren[arr_raddr[AW-1:PG_LSB]] |-> arr_rdata == FIXED_RD);

  p_fault_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq && !(reg_wr && reg_addr == 8'h18 && !reg_wdata[0]) |=> fault_irq);
endmodule

bind flash_pe_ctrl flash_pe_ctrl_chk #(.AW(AW), .PG_LSB(PG_LSB), .FIXED_RD(FIXED_RD)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .busy(busy), .fault_irq(fault_irq), .wen(wen_q), .ren(ren_q),
  .arr_raddr(arr_raddr), .arr_rdata(arr_rdata)
);

// File: tb/flash_pe_ctrl_tb.sv
module flash_pe_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9, WORDS = 32, WPP = 4;
  localparam int PT = 4, ET = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [AW-1:0] arr_raddr = '0;
  logic [31:0]   arr_rdata;
  logic          busy, fault_irq;

  int total = 0, bad = 0;
  logic [127:0] model [WORDS];
  logic [7:0]   rprot = '0;
  logic [31:0]  rv;
  int           cyc;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_pe_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata),
    .busy(busy), .fault_irq(fault_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_op(output int n);
    n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic load(input logic [31:0] a, input logic [127:0] d);
    wr(8'h00, a);
    wr(8'h04, d[31:0]);
    wr(8'h08, d[63:32]);
    wr(8'h0C, d[95:64]);
    wr(8'h10, d[127:96]);
  endtask

  task automatic sweep(input string tag);
    for (int w = 0; w < WORDS; w++) begin
      for (int l = 0; l < 4; l++) begin
        arr_raddr = AW'(w * 16 + l * 4);
        #1;
        chk(tag, arr_rdata, rprot[w / WPP] ? 32'h0 : model[w][l*32 +: 32]);
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int w = 0; w < WORDS; w++) model[w] = '1;
    rprot = '0;
  endtask

  task automatic clr_fault();
    wr(8'h18, 32'h0);
    chk("R12 clear by 0", {31'd0, fault_irq}, 32'd0);
  endtask

  task automatic reset_checks();
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 fault", {31'd0, fault_irq}, 32'd0);
    rd(8'h20, rv); chk("R1 wen lo", rv, 32'h0000_00FF);
    rd(8'h24, rv); chk("R1 wen hi", rv, 32'h0);
    rd(8'h28, rv); chk("R1 ren lo", rv, 32'h0000_00FF);
    rd(8'h2C, rv); chk("R1 ren hi", rv, 32'h0);
    sweep("R1 array ones");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] d;
    do_reset();
    reset_checks();

    // R2 R3 R4: basic program
    wr(8'h1C, 32'd2);
    d = {32'h0F0F_0F0F, 32'hA5A5_5A5A, 32'h1234_5678, 32'h1122_3344};
    load(32'h10, d);
    wr(8'h14, 32'h9000_0001);
    rd(8'h14, rv);
    chk("R4 running bits", rv & 32'h0001_0007, 32'h0001_0001);
    wait_op(cyc);
    chk("R3 program cycles", cyc, PT * 2);
    rd(8'h14, rv);
    chk("R4 cleared bits", rv & 32'h0001_0007, 32'h0);
    model[1] = model[1] & d;
    sweep("R2 program");

    // R2: attempt 0->1, only clears
    d = {32'hFFFF_0000, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'hF0F0_F0F0};
    load(32'h10, d);
    wr(8'h14, 32'h9000_0001);
    wait_op(cyc);
    model[1] = model[1] & d;
    sweep("R2 and-merge");

    // R13 address mask
    wr(8'h00, 32'hFFFF_FF40);
    rd(8'h00, rv);
    chk("R13 addr mask", rv, 32'h0000_0140);

    // R7 unaligned
    wr(8'h00, 32'h24);
    wr(8'h14, 32'h9000_0001);
    chk("R7 fault", {31'd0, fault_irq}, 32'd1);
    chk("R7 no busy", {31'd0, busy}, 32'd0);
    wr(8'h18, 32'h1);
    chk("R12 write 1 keeps", {31'd0, fault_irq}, 32'd1);
    clr_fault();
    sweep("R7 unchanged");

    // R5 locked
    load(32'h40, 128'h0);
    wr(8'h14, 32'h0000_0001);
    chk("R5 fault", {31'd0, fault_irq}, 32'd1);
    chk("R5 no busy", {31'd0, busy}, 32'd0);
    clr_fault();
    sweep("R5 unchanged");

    // R6 start while busy, register writes ignored
    d = {32'h0, 32'h00FF_00FF, 32'hFFFF_FFFF, 32'h8765_4321};
    load(32'h40, d);
    wr(8'h14, 32'h9000_0001);
    wr(8'h14, 32'h9000_0A02);
    chk("R6 fault", {31'd0, fault_irq}, 32'd1);
    wr(8'h00, 32'h80);
    wr(8'h1C, 32'd7);
    rd(8'h00, rv); chk("R6 addr held", rv, 32'h40);
    rd(8'h1C, rv); chk("R6 div held", rv, 32'd2);
    wait_op(cyc);
    model[4] = model[4] & d;
    sweep("R6 op intact");
    clr_fault();

    // R8 wrong erase code
    wr(8'h00, 32'h0);
    wr(8'h14, 32'h9000_0502);
    chk("R8 bad code fault", {31'd0, fault_irq}, 32'd1);
    chk("R8 bad code idle", {31'd0, busy}, 32'd0);
    clr_fault();

    // R8 R3 page erase page 0 at div 3
    wr(8'h1C, 32'd3);
    wr(8'h14, 32'h9000_0A02);
    wait_op(cyc);
    chk("R3 erase cycles", cyc, ET * 3);
    for (int j = 0; j < WPP; j++) model[j] = '1;
    sweep("R8 page erase");

    // R10 write protect page 1
    wr(8'h20, 32'h2);
    rd(8'h20, rv); chk("R10 wen cleared", rv, 32'hFD);
    wr(8'h20, 32'h0);
    rd(8'h20, rv); chk("R10 wen sticky", rv, 32'hFD);
    load(32'h40, 128'h0);
    wr(8'h14, 32'h9000_0001);
    wait_op(cyc);
    chk("R10 full length", cyc, PT * 3);
    chk("R10 fault", {31'd0, fault_irq}, 32'd1);
    rd(8'h14, rv); chk("R10 go cleared", rv & 32'h7, 32'h0);
    sweep("R10 unchanged");
    clr_fault();
    wr(8'h14, 32'h9000_0A02);
    wait_op(cyc);
    chk("R10 erase fault", {31'd0, fault_irq}, 32'd1);
    sweep("R10 erase unchanged");
    clr_fault();

    // R9 whole-array erase blocked by protection
    wr(8'h14, 32'h9000_0504);
    wait_op(cyc);
    chk("R9 blocked length", cyc, ET * 3);
    chk("R9 blocked fault", {31'd0, fault_irq}, 32'd1);
    sweep("R9 unchanged");
    clr_fault();

    // R11 read protect page 2
    d = {32'h1357_9BDF, 32'h2468_ACE0, 32'h0, 32'hCAFE_F00D};
    load(32'h80, d);
    wr(8'h14, 32'h9000_0001);
    wait_op(cyc);
    model[8] = model[8] & d;
    wr(8'h28, 32'h4);
    rprot[2] = 1'b1;
    rd(8'h28, rv); chk("R11 ren cleared", rv, 32'hFB);
    wr(8'h28, 32'h0);
    rd(8'h28, rv); chk("R11 ren sticky", rv, 32'hFB);
    sweep("R11 read protect");

    // R1 after reset, R9 whole erase, R3 div 0
    do_reset();
    reset_checks();
    wr(8'h1C, 32'd0);
    load(32'h1F0, {4{32'h5555_AAAA}});
    wr(8'h14, 32'h9000_0001);
    wait_op(cyc);
    chk("R3 div zero as one", cyc, PT);
    model[31] = model[31] & {4{32'h5555_AAAA}};
    sweep("R2 last word");
    wr(8'h1C, 32'd1);
    wr(8'h14, 32'h9000_0504);
    wait_op(cyc);
    chk("R3 whole erase cycles", cyc, ET);
    chk("R9 no fault", {31'd0, fault_irq}, 32'd0);
    for (int w = 0; w < WORDS; w++) model[w] = '1;
    sweep("R9 whole erase");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule